// File: doc/BRIEF.md
# Sixteen-Slot Measurement Sequencer

This block paces one repeating transient measurement. A slot counter steps once per accepted timebase tick through sixteen time slots and wraps around, and the current slot is shown on sixteen active-low strobes, exactly one of which is low at any time. From the slot position the block derives the control signals for one measurement cycle:
- a single-cycle trigger that starts the bias (filling) pulse on the sample, issued on entry to slot 0;
- two rate-window sample gates, at slots 3 and 13, which gives a second-to-first sample time ratio of about 4.33;
- a baseline sample gate at slot 15, late in the transient.

The first gate sits at slot 3 on purpose. This keeps it away from the recovery that follows the pulse.

The sample gates drive track/hold amplifiers. A high level means track the input, and a low level means hold the stored value. A hold input freezes the counter on its current slot. When the hold is released, the sequence continues from that slot. The timebase tick comes from outside the block.

Top module: `slot_seq`

## Requirements
- R1: During and after reset the counter is at slot 0: `slotN` equals 16'hFFFE, and `trigOut`, `gateFirst`, `gateSecond` and `gateBase` are all low.
- R2: On a clock edge where `tickIn` is high and `holdIn` is low, the slot advances by exactly one. Otherwise the slot is unchanged.
- R3: An accepted tick in slot 15 moves the counter to slot 0.
- R4: Exactly one bit of `slotN` is low at all times, and that bit's index is the current slot number.
- R5: `trigOut` is high for exactly one clock cycle, in the first cycle of slot 0 when slot 0 is entered from slot 15. Leaving reset does not raise it.
- R6: `gateFirst` is high throughout slot 3 and low in every other slot.
- R7: `gateSecond` is high throughout slot 13 and low in every other slot.
- R8: `gateBase` is high throughout slot 15 and low in every other slot.
- R9: While `holdIn` is high, ticks are ignored. The counter keeps its slot and resumes from that slot once `holdIn` falls.
- R10: No two of the three sample gates are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | Timebase tick, one clock wide per step |
| holdIn | input | 1 | Freeze the slot counter while high |
| slotN | output | 16 | One-hot active-low slot strobes, bit k low in slot k |
| trigOut | output | 1 | Bias pulse trigger, one cycle wide |
| gateFirst | output | 1 | First rate-window sample enable (high = track) |
| gateSecond | output | 1 | Second rate-window sample enable (high = track) |
| gateBase | output | 1 | Baseline sample enable (high = track) |

## Verification
Two pairs of events can fall in the same cycle:
- a tick arriving while hold is high, where the hold must win and the slot must stay put;
- the wrap from slot 15, which must raise the trigger in the same cycle that the baseline gate drops and the slot-0 strobe goes low.

The stimulus mixes random tick and hold levels, so both pairs occur often. It also includes directed runs that park the counter on slot 15 under hold and then tick it there, and that hold it on slot 3 and slot 13 across several ticks. Every cycle, a bench model of the slot and trigger is compared with the strobes, the trigger and all three gates.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic advance;  // accepted tick: step the counter
    logic wrap;     // accepted tick in the last slot: return to slot 0
  } seqStrobe_t;
endpackage

// File: rtl/slot_seq_control.sv
module slot_seq_control #(
  parameter int SLOTS  = 16,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     tickIn,
  input  logic                     holdIn,
  input  logic [SLOT_W-1:0]        slot,
  output slot_seq_pkg::seqStrobe_t strobe,
  output logic                     trigOut
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic accept;
  assign accept        = tickIn && !holdIn;
  assign strobe.advance = accept;
  assign strobe.wrap    = accept && (slot == LAST_SLOT);

  // Trigger registered alongside the counter, so it rises with entry to slot 0
  always_ff @(posedge clk) begin
    if (!rstN) trigOut <= 1'b0;
    else       trigOut <= strobe.wrap;
  end

  p_trig_in_slot0_r5: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |-> (slot == '0));
  p_trig_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |=> !trigOut);
  p_trig_from_last_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tickIn && !holdIn && slot == LAST_SLOT) |=> (trigOut && slot == '0));
endmodule

// File: rtl/slot_seq_datapath.sv
module slot_seq_datapath #(
  parameter int SLOTS       = 16,
  parameter int FIRST_SLOT  = 3,
  parameter int SECOND_SLOT = 13,
  parameter int BASE_SLOT   = 15,
  localparam int SLOT_W     = $clog2(SLOTS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  slot_seq_pkg::seqStrobe_t strobe,
  output logic [SLOT_W-1:0]        slot,
  output logic [SLOTS-1:0]         slotN,
  output logic                     gateFirst,
  output logic                     gateSecond,
  output logic                     gateBase
);
  logic [SLOT_W-1:0] slotNext;

  always_comb begin
    slotNext = slot;
    if (strobe.wrap)         slotNext = '0;
    else if (strobe.advance) slotNext = slot + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) slot <= '0;
    else       slot <= slotNext;
  end

  // Active-low one-hot decode of the slot number
  for (genvar k = 0; k < SLOTS; k++) begin : g_decode
    assign slotN[k] = (slot != SLOT_W'(k));
  end

  // Sample enables taken from the decoded strobes (high = track)
  assign gateFirst  = !slotN[FIRST_SLOT];
  assign gateSecond = !slotN[SECOND_SLOT];
  assign gateBase   = !slotN[BASE_SLOT];

  p_onehot_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~slotN) == 1);
  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.wrap) |=> (slot == $past(slot) + 1'b1));
  p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> $stable(slot));
  p_gates_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({gateFirst, gateSecond, gateBase}));
  p_first_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    gateFirst |-> (slot == SLOT_W'(FIRST_SLOT)));
endmodule

// File: rtl/slot_seq.sv
module slot_seq #(
  parameter int SLOTS       = 16,
  parameter int FIRST_SLOT  = 3,
  parameter int SECOND_SLOT = 13,
  parameter int BASE_SLOT   = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickIn,
  input  logic             holdIn,
  output logic [SLOTS-1:0] slotN,
  output logic             trigOut,
  output logic             gateFirst,
  output logic             gateSecond,
  output logic             gateBase
);
  localparam int SLOT_W = $clog2(SLOTS);

  slot_seq_pkg::seqStrobe_t strobe;
  logic [SLOT_W-1:0]        slot;

  slot_seq_control #(.SLOTS(SLOTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .holdIn(holdIn),
    .slot(slot), .strobe(strobe), .trigOut(trigOut)
  );

  slot_seq_datapath #(
    .SLOTS(SLOTS), .FIRST_SLOT(FIRST_SLOT),
    .SECOND_SLOT(SECOND_SLOT), .BASE_SLOT(BASE_SLOT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slot(slot), .slotN(slotN),
    .gateFirst(gateFirst), .gateSecond(gateSecond), .gateBase(gateBase)
  );
endmodule

// File: tb/slot_seq_tb.sv
module slot_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickIn = 1'b0;
  logic        holdIn = 1'b0;
  logic [15:0] slotN;
  logic        trigOut, gateFirst, gateSecond, gateBase;

  int total = 0;
  int bad = 0;
  int expSlot = 0;
  bit expTrig = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  slot_seq u_dut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .holdIn(holdIn),
    .slotN(slotN), .trigOut(trigOut), .gateFirst(gateFirst),
    .gateSecond(gateSecond), .gateBase(gateBase)
  );

  function automatic logic [15:0] expStrobes(int s);
    return ~(16'h1 << s);
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h (slot %0d)", tag, act, exp, expSlot);
    end
  endtask

  task automatic checkAll(string slotTag);
    check(slotTag, slotN, expStrobes(expSlot));
    check("R4", 16'($countones(~slotN)), 16'd1);
    check("R5", {15'd0, trigOut}, {15'd0, expTrig});
    check("R6", {15'd0, gateFirst},  {15'd0, expSlot == 3});
    check("R7", {15'd0, gateSecond}, {15'd0, expSlot == 13});
    check("R8", {15'd0, gateBase},   {15'd0, expSlot == 15});
    check("R10", 16'(gateFirst + gateSecond + gateBase), 16'(expSlot == 3 || expSlot == 13 || expSlot == 15));
  endtask

  // Drive inputs just after an edge, then check just after the next one
  task automatic step(bit t, bit h);
    string tag;
    tickIn = t;
    holdIn = h;
    @(posedge clk);
    #1;
    expTrig = t && !h && expSlot == 15;
    if (t && !h) begin
      tag = (expSlot == 15) ? "R3" : "R2";
      expSlot = (expSlot + 1) % 16;
    end else begin
      tag = (t && h) ? "R9" : "R2";
    end
    checkAll(tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", slotN, 16'hFFFE);
    check("R1", {12'd0, trigOut, gateFirst, gateSecond, gateBase}, 16'd0);
    rstN = 1'b1;
    step(0, 0);
    check("R1", {15'd0, trigOut}, 16'd0);
    // Full runs of ticks on every cycle: two wraps, trigger each time
    repeat (34) step(1, 0);
    // Spaced ticks
    repeat (20) begin step(1, 0); step(0, 0); step(0, 0); end
    // Walk to slot 15, then hold it there while ticking (R9)
    while (expSlot != 15) step(1, 0);
    repeat (5) step(1, 1);
    step(1, 0);  // wrap and trigger coincide with release
    // Park on slot 3 and slot 13 under hold
    while (expSlot != 3) step(1, 0);
    repeat (4) step(1, 1);
    step(0, 0);
    while (expSlot != 13) step(1, 0);
    repeat (4) step($urandom_range(0, 1), 1);
    // Random mix of tick and hold
    repeat (1500) step($urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0);
    // Reset mid-sequence returns to slot 0 with no trigger (R1)
    tickIn = 1'b0;
    holdIn = 1'b0;
    rstN = 1'b0;
    @(posedge clk);
    #1;
    expSlot = 0;
    expTrig = 1'b0;
    checkAll("R1");
    rstN = 1'b1;
    repeat (40) step(1, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule